// File: doc/BRIEF.md
# Shared Packet Pool Switch Hub

This block is the central switch of a small byte-stream fabric. Several ingress ports hand it bytes one at a time over a valid/ready handshake, and every byte goes straight into one shared packet memory that is divided into fixed-size slots. The ports keep no packet storage of their own. The first byte of a packet claims the lowest free slot. Later bytes from the same port are appended to that port's open slot. If no slot is free, the packet is discarded, but its bytes are still counted so that the next packet starts on the right byte.

Every packet has the same length, set by a 2-bit length code. When the last byte of a packet arrives, the hub looks at the header. Byte 0 is the destination address, byte 1 is the command field and byte 2 is the argument. Packets for another port produce a one-cycle notification on that egress port, carrying the slot index. The egress side then fetches the bytes through a shared read port and hands the slot back with a release strobe.

Packets addressed to the hub itself are consumed as commands. A command with an all-zero command field sets a new packet length code. The last slot is held back for hub commands, so that control traffic still gets through while the general pool is exhausted. A congestion flag, seen by every port, reports that the general pool has no free slot.

Top module: `pkt_pool_hub`

## Requirements
- R1: After a synchronous active-high reset, `rx_ready`, `ntf_valid`, `hub_cmd_valid` and `pool_full` are all low, and the length code is 0.
- R2: The hub accepts at most one byte per clock cycle. `rx_ready` is high only for the single granted port. The grant goes to the first requesting port at or after a rotating pointer, which is 0 after reset and moves to the port just after the last granted one.
- R3: The first byte of a packet is given the lowest-numbered free general slot (slots 0 to NSLOT-2). Byte k of the packet is stored at offset k of its slot. The read port returns the byte at (`rd_slot`, `rd_addr`) one cycle after those inputs are sampled.
- R4: Packet length codes 0, 1, 2 and 3 select LEN0, LEN1, LEN2 and LEN3 bytes (64, 128, 256 and 1024 by default). The code in force when a packet's first byte is accepted applies to the whole packet.
- R5: In the cycle after the last byte of a forwarded packet is accepted, `ntf_valid[e]` pulses for one cycle and lane e of `ntf_slot` carries the slot index. The egress port e is chosen from byte 0: address a in 1..NPORT selects port a-1, and any other nonzero address selects port 0.
- R6: A packet whose first byte finds no slot available is dropped. All of its bytes are still accepted and counted up to the packet length, nothing is stored, and no notification or command pulse is produced. The following packet is handled normally.
- R7: `pool_full` is high exactly while every general slot is in use.
- R8: A packet with destination address 0 is a hub command. It takes a free general slot if one exists, otherwise the reserved slot NSLOT-1. On completion, `hub_cmd_valid` pulses for one cycle with `hub_cmd_code` equal to byte 1, no notification is sent, and the hub frees the slot itself.
- R9: A hub command whose byte 1 is zero loads bits [1:0] of byte 2 as the new length code. Packets that start afterwards use it.
- R10: A `rel_valid` strobe frees slot `rel_slot`. If an allocation and a release happen in the same cycle, both take effect. The allocation is chosen from the slot usage before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | NPORT | Byte offered, one bit per ingress port |
| rx_data | input | NPORT*8 | Offered bytes, port p in bits [8p+7:8p] |
| rx_ready | output | NPORT | Byte of that port is taken at this clock edge |
| ntf_valid | output | NPORT | One-cycle packet-ready notification per egress port |
| ntf_slot | output | NPORT*SW | Slot index of the notified packet, one lane per egress port |
| pool_full | output | 1 | No general slot free (congestion flag) |
| hub_cmd_valid | output | 1 | One-cycle pulse when a hub command packet completes |
| hub_cmd_code | output | 8 | Command field of the last completed hub command |
| rel_valid | input | 1 | Release strobe from the egress side |
| rel_slot | input | SW | Slot to release |
| rd_slot | input | SW | Read port slot index |
| rd_addr | input | CW | Read port byte offset within the slot |
| rd_data | output | 8 | Byte read, one cycle after the address |

## Verification
The bench builds the hub with four ports, four slots (three general and one reserved), 16-byte slots, and packet lengths of 4, 6, 8 and 16 bytes. With this setup, every ingress port can be paired with every egress address in a short sweep. The pool can be driven to full after only three packets, and the reserved slot comes into play at once. The bench can also step through all four length codes with hub commands and watch the notification hold off until exactly the last byte. Drops, the realignment after a drop, a release in the same cycle as an allocation, and the rotating grant all fit within a few hundred cycles.

// File: rtl/hub_pkg.sv
package hub_pkg;

  // Packet length selected by the 2-bit length code.
  function automatic int code_len(input logic [1:0] code, input int l0,
                                  input int l1, input int l2, input int l3);
    case (code)
      2'd0:    return l0;
      2'd1:    return l1;
      2'd2:    return l2;
      default: return l3;
    endcase
  endfunction

  // Egress port chosen from a nonzero header address.
  function automatic int egress_of(input logic [7:0] addr, input int nport);
    int a;
    a = int'(addr);
    if (a >= 1 && a <= nport) return a - 1;
    return 0;
  endfunction

  // First requester at or after 'start', or -1 if nobody requests.
  function automatic int rr_pick(input logic [31:0] req, input int n, input int start);
    int res;
    res = -1;
    for (int k = 0; k < n; k++) begin
      int i;
      i = start + k;
      if (i >= n) i = i - n;
      if (res < 0 && req[i]) res = i;
    end
    return res;
  endfunction

  // Lowest clear bit among the first n, or -1 if all are set.
  function automatic int lowest_free(input logic [31:0] used, input int n);
    int res;
    res = -1;
    for (int i = 0; i < n; i++) begin
      if (res < 0 && !used[i]) res = i;
    end
    return res;
  endfunction

endpackage

// File: rtl/hub_rr_arb.sv
module hub_rr_arb
  import hub_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx,
  output logic          any
);

  logic [IW-1:0] ptr_q;
  int            pick;

  always_comb begin
    pick  = rr_pick(32'(req), N, int'(ptr_q));
    any   = (pick >= 0);
    gidx  = any ? IW'(pick) : '0;
    grant = any ? (N'(1) << gidx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (any) begin
      ptr_q <= (int'(gidx) == N - 1) ? '0 : gidx + IW'(1);
    end
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  // R2
  grant_req_chk: assert property (@(posedge clk) disable iff (rst) any |-> req[gidx]);

endmodule

// File: rtl/hub_slot_pool.sv
module hub_slot_pool
  import hub_pkg::*;
#(
  parameter int NSLOT = 4,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  input  logic             alloc_hub,
  input  logic [NSLOT-1:0] rel_mask,
  output logic             alloc_ok,
  output logic [SW-1:0]    alloc_idx,
  output logic             full
);

  localparam int NGEN = NSLOT - 1;

  logic [NSLOT-1:0] used_q;
  logic             found;
  int               g;

  always_comb begin
    g         = lowest_free(32'(used_q), NGEN);
    found     = 1'b0;
    alloc_idx = '0;
    if (g >= 0) begin
      found     = 1'b1;
      alloc_idx = SW'(g);
    end else if (alloc_hub && !used_q[NSLOT-1]) begin
      found     = 1'b1;
      alloc_idx = SW'(NSLOT - 1);
    end
    alloc_ok = alloc_req && found;
    full     = &used_q[NGEN-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
    end else begin
      used_q <= (used_q & ~rel_mask) | (alloc_ok ? (NSLOT'(1) << alloc_idx) : '0);
    end
  end

  // R3
  alloc_free_chk: assert property (@(posedge clk) disable iff (rst) alloc_ok |-> !used_q[alloc_idx]);
  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (rst) (full && !alloc_hub) |-> !alloc_ok);

  for (genvar s = 0; s < NSLOT; s++) begin : g_rel
    // R10
    release_take_chk: assert property (@(posedge clk) disable iff (rst)
      (rel_mask[s] && !(alloc_ok && int'(alloc_idx) == s)) |=> !used_q[s]);
  end

endmodule

// File: rtl/hub_pkt_mem.sv
module hub_pkt_mem #(
  parameter int DEPTH = 4096,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pkt_pool_hub.sv
module pkt_pool_hub
  import hub_pkg::*;
#(
  parameter int NPORT      = 4,
  parameter int NSLOT      = 4,
  parameter int SLOT_BYTES = 1024,
  parameter int LEN0       = 64,
  parameter int LEN1       = 128,
  parameter int LEN2       = 256,
  parameter int LEN3       = 1024,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW = $clog2(SLOT_BYTES),
  localparam int EW = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int AW = $clog2(NSLOT * SLOT_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPORT-1:0]   rx_valid,
  input  logic [NPORT*8-1:0] rx_data,
  output logic [NPORT-1:0]   rx_ready,
  output logic [NPORT-1:0]   ntf_valid,
  output logic [NPORT*SW-1:0] ntf_slot,
  output logic               pool_full,
  output logic               hub_cmd_valid,
  output logic [7:0]         hub_cmd_code,
  input  logic               rel_valid,
  input  logic [SW-1:0]      rel_slot,
  input  logic [SW-1:0]      rd_slot,
  input  logic [CW-1:0]      rd_addr,
  output logic [7:0]         rd_data
);

  // Per-port open packet state
  logic [NPORT-1:0] busy_q, drop_q;
  logic [CW-1:0]    cnt_q  [NPORT];
  logic [SW-1:0]    slot_q [NPORT];
  logic [1:0]       code_q [NPORT];
  logic [7:0]       dest_q [NPORT];
  logic [7:0]       cmd_q  [NPORT];
  logic [1:0]       arg_q  [NPORT];
  logic [1:0]       len_code_q;

  // Named internal events
  logic             fire, first, last_byte, drop_cur, done_fwd, done_cmd;
  logic [EW-1:0]    sel, egress;
  logic [7:0]       in_byte, dest_cur, cmd_cur;
  logic [1:0]       code_cur, arg_cur;
  logic [CW-1:0]    cnt_cur;
  logic [SW-1:0]    slot_cur, alloc_idx;
  logic             alloc_ok;
  logic [NSLOT-1:0] rel_mask;
  logic             mem_we;
  logic [AW-1:0]    mem_waddr, mem_raddr;
  int               plen;

  hub_rr_arb #(.N(NPORT)) u_arb (
    .clk(clk), .rst(rst), .req(rx_valid), .grant(rx_ready), .gidx(sel), .any(fire)
  );

  always_comb begin
    in_byte   = rx_data[int'(sel)*8 +: 8];
    first     = !busy_q[sel];
    cnt_cur   = first ? '0 : cnt_q[sel];
    code_cur  = first ? len_code_q : code_q[sel];
    plen      = code_len(code_cur, LEN0, LEN1, LEN2, LEN3);
    last_byte = fire && (int'(cnt_cur) == plen - 1);
    drop_cur  = first ? !alloc_ok : drop_q[sel];
    slot_cur  = first ? alloc_idx : slot_q[sel];
    dest_cur  = first ? in_byte : dest_q[sel];
    cmd_cur   = (cnt_cur == CW'(1)) ? in_byte : cmd_q[sel];
    arg_cur   = (cnt_cur == CW'(2)) ? in_byte[1:0] : arg_q[sel];
    done_fwd  = last_byte && !drop_cur && (dest_cur != 8'd0);
    done_cmd  = last_byte && !drop_cur && (dest_cur == 8'd0);
    egress    = EW'(egress_of(dest_cur, NPORT));
    mem_we    = fire && !drop_cur;
    mem_waddr = AW'(slot_cur) * AW'(SLOT_BYTES) + AW'(cnt_cur);
    mem_raddr = AW'(rd_slot) * AW'(SLOT_BYTES) + AW'(rd_addr);
    rel_mask  = (rel_valid ? (NSLOT'(1) << rel_slot) : '0)
              | (done_cmd ? (NSLOT'(1) << slot_cur) : '0);
  end

  hub_slot_pool #(.NSLOT(NSLOT)) u_pool (
    .clk(clk), .rst(rst), .alloc_req(fire && first), .alloc_hub(in_byte == 8'd0),
    .rel_mask(rel_mask), .alloc_ok(alloc_ok), .alloc_idx(alloc_idx), .full(pool_full)
  );

  hub_pkt_mem #(.DEPTH(NSLOT * SLOT_BYTES)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(in_byte),
    .raddr(mem_raddr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q        <= '0;
      drop_q        <= '0;
      ntf_valid     <= '0;
      ntf_slot      <= '0;
      hub_cmd_valid <= 1'b0;
      hub_cmd_code  <= '0;
      len_code_q    <= 2'd0;
      for (int p = 0; p < NPORT; p++) begin
        cnt_q[p]  <= '0;
        slot_q[p] <= '0;
        code_q[p] <= '0;
        dest_q[p] <= '0;
        cmd_q[p]  <= '0;
        arg_q[p]  <= '0;
      end
    end else begin
      ntf_valid     <= done_fwd ? (NPORT'(1) << egress) : '0;
      hub_cmd_valid <= done_cmd;
      if (done_fwd) ntf_slot[int'(egress)*SW +: SW] <= slot_cur;
      if (done_cmd) begin
        hub_cmd_code <= cmd_cur;
        if (cmd_cur == 8'd0) len_code_q <= arg_cur;
      end
      if (fire) begin
        busy_q[sel] <= !last_byte;
        drop_q[sel] <= drop_cur;
        cnt_q[sel]  <= cnt_cur + CW'(1);
        slot_q[sel] <= slot_cur;
        code_q[sel] <= code_cur;
        dest_q[sel] <= dest_cur;
        cmd_q[sel]  <= cmd_cur;
        arg_q[sel]  <= arg_cur;
      end
    end
  end

  // R5
  ntf_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(ntf_valid));
  // R6
  drop_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (last_byte && drop_cur) |=> (ntf_valid == '0 && !hub_cmd_valid));
  // R8
  cmd_no_ntf_chk: assert property (@(posedge clk) disable iff (rst)
    hub_cmd_valid |-> (ntf_valid == '0));
  // R9
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(done_cmd) |-> $stable(len_code_q));

endmodule

// File: tb/pkt_pool_hub_test.sv
`timescale 1ns/1ps
module pkt_pool_hub_test;

  localparam int NP = 4, NS = 4, SB = 16, SWT = 2, CWT = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NP-1:0]   rx_valid = '0;
  logic [NP*8-1:0] rx_data = '0;
  logic [NP-1:0]   rx_ready, ntf_valid;
  logic [NP*SWT-1:0] ntf_slot;
  logic            pool_full, hub_cmd_valid;
  logic [7:0]      hub_cmd_code, rd_data;
  logic            rel_valid = 1'b0;
  logic [SWT-1:0]  rel_slot = '0, rd_slot = '0;
  logic [CWT-1:0]  rd_addr = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pkt_pool_hub #(.NPORT(NP), .NSLOT(NS), .SLOT_BYTES(SB),
                 .LEN0(4), .LEN1(6), .LEN2(8), .LEN3(16)) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .ntf_valid(ntf_valid), .ntf_slot(ntf_slot), .pool_full(pool_full),
    .hub_cmd_valid(hub_cmd_valid), .hub_cmd_code(hub_cmd_code),
    .rel_valid(rel_valid), .rel_slot(rel_slot), .rd_slot(rd_slot), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  function automatic int lenof(input int code);
    return 4 + 2 * code + ((code == 3) ? 6 : 0);
  endfunction

  function automatic logic [7:0] pat(input int p, input int k, input logic [7:0] d,
                                     input logic [7:0] c, input logic [7:0] a);
    if (k == 0) return d;
    if (k == 1) return c;
    if (k == 2) return a;
    return 8'(8'h30 + p * 16 + k);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_valid = '0; rel_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_byte(input int p, input logic [7:0] d);
    @(negedge clk);
    rx_valid[p] = 1'b1;
    rx_data[p*8 +: 8] = d;
    #1;
    while (!rx_ready[p]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    rx_valid[p] = 1'b0;
  endtask

  // Sends a whole packet; returns at the negedge after the last byte.
  task automatic send_pkt(input int p, input logic [7:0] d, input logic [7:0] c,
                          input logic [7:0] a, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      send_byte(p, pat(p, k, d, c, a));
      @(negedge clk);
      if (k < n - 1)
        chk(ntf_valid == '0 && !hub_cmd_valid, req, int'(ntf_valid), 0);
    end
  endtask

  task automatic expect_ntf(input int e, input int s, input string req);
    chk(ntf_valid == NP'(1 << e), req, int'(ntf_valid), 1 << e);
    chk(int'(ntf_slot[e*SWT +: SWT]) == s, req, int'(ntf_slot[e*SWT +: SWT]), s);
  endtask

  task automatic release_slot(input int s);
    @(negedge clk);
    rel_valid = 1'b1;
    rel_slot = SWT'(s);
    @(posedge clk);
    #1;
    rel_valid = 1'b0;
  endtask

  task automatic read_chk(input int s, input int a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_slot = SWT'(s);
    rd_addr = CWT'(a);
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == exp, req, int'(rd_data), int'(exp));
  endtask

  initial begin
    int cur_code;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(rx_ready == '0 && ntf_valid == '0 && !hub_cmd_valid && !pool_full,
        "R1", int'({rx_ready, ntf_valid}), 0);

    // R3 R5 sweep of every ingress port against every egress address
    for (int p = 0; p < NP; p++) begin
      for (int d = 1; d <= NP; d++) begin
        send_pkt(p, 8'(d), 8'h55, 8'(p), 4, "R4");
        expect_ntf(d - 1, 0, "R5");
        chk(!pool_full, "R7", int'(pool_full), 0);
        for (int k = 0; k < 4; k++)
          read_chk(0, k, pat(p, k, 8'(d), 8'h55, 8'(p)), "R3");
        release_slot(0);
      end
    end
    // R5 out-of-range address goes to port 0
    send_pkt(2, 8'd9, 8'h11, 8'h00, 4, "R4");
    expect_ntf(0, 0, "R5");
    release_slot(0);

    // R3 R7 fill the general pool
    send_pkt(0, 8'd2, 8'h01, 8'h00, 4, "R4");
    expect_ntf(1, 0, "R3");
    send_pkt(1, 8'd3, 8'h01, 8'h00, 4, "R4");
    expect_ntf(2, 1, "R3");
    chk(!pool_full, "R7", int'(pool_full), 0);
    send_pkt(2, 8'd4, 8'h01, 8'h00, 4, "R4");
    expect_ntf(3, 2, "R3");
    chk(pool_full, "R7", int'(pool_full), 1);

    // R6 drop while full, then realigned packet
    send_pkt(3, 8'd1, 8'h01, 8'h00, 4, "R6");
    chk(ntf_valid == '0 && !hub_cmd_valid, "R6", int'(ntf_valid), 0);
    release_slot(1);
    @(negedge clk);
    chk(!pool_full, "R7", int'(pool_full), 0);
    send_pkt(3, 8'd1, 8'h01, 8'h00, 4, "R6");
    expect_ntf(0, 1, "R6");
    chk(pool_full, "R7", int'(pool_full), 1);

    // R8 hub command into reserved slot while full; R9 sets code 1
    send_pkt(1, 8'd0, 8'h00, 8'h01, 4, "R8");
    chk(hub_cmd_valid && hub_cmd_code == 8'h00, "R8", int'(hub_cmd_code), 0);
    chk(ntf_valid == '0, "R8", int'(ntf_valid), 0);
    read_chk(3, 2, 8'h01, "R8");
    // R8 reserved slot was freed by the hub, second command gets through
    send_pkt(2, 8'd0, 8'h07, 8'h03, 6, "R9");
    chk(hub_cmd_valid && hub_cmd_code == 8'h07, "R8", int'(hub_cmd_code), 7);
    release_slot(0);
    release_slot(1);
    release_slot(2);

    // R4 R9 step through the length codes
    cur_code = 1;
    send_pkt(0, 8'd2, 8'h22, 8'h00, lenof(cur_code), "R9");
    expect_ntf(1, 0, "R9");
    release_slot(0);
    for (int c = 2; c <= 4; c++) begin
      int nc;
      nc = c % 4;
      send_pkt(0, 8'd0, 8'h00, 8'(nc), lenof(cur_code), "R4");
      chk(hub_cmd_valid && hub_cmd_code == 8'h00, "R9", int'(hub_cmd_valid), 1);
      cur_code = nc;
      send_pkt(1, 8'd3, 8'h33, 8'h00, lenof(cur_code), "R4");
      expect_ntf(2, 0, "R4");
      release_slot(0);
    end

    // R10 allocation and release in the same cycle
    send_pkt(0, 8'd2, 8'h01, 8'h00, 4, "R4");
    expect_ntf(1, 0, "R10");
    @(negedge clk);
    rel_valid = 1'b1;
    rel_slot = 2'd0;
    rx_valid[1] = 1'b1;
    rx_data[15:8] = 8'd3;
    #1;
    chk(rx_ready == 4'b0010, "R10", int'(rx_ready), 2);
    @(posedge clk);
    #1;
    rel_valid = 1'b0;
    rx_valid[1] = 1'b0;
    for (int k = 1; k < 4; k++) send_byte(1, pat(1, k, 8'd3, 8'h01, 8'h00));
    @(negedge clk);
    expect_ntf(2, 1, "R10");
    send_pkt(2, 8'd1, 8'h01, 8'h00, 4, "R10");
    expect_ntf(0, 0, "R10");

    // R2 rotating grant
    do_reset();
    @(negedge clk);
    rx_valid = 4'b0110;
    rx_data = 32'h0002_0200;
    #1;
    chk(rx_ready == 4'b0010, "R2", int'(rx_ready), 2);
    @(posedge clk);
    #1;
    chk(rx_ready == 4'b0100, "R2", int'(rx_ready), 4);
    @(posedge clk);
    #1;
    rx_valid = '0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule